// File: doc/BRIEF.md
# Byte Serial Port Controller (master/slave)

This block moves one byte at a time over a four-wire synchronous serial link, and a processor controls it through three byte-wide registers. As bus master it makes the serial clock from the system clock. A write to the data register sends eight bits out while eight bits come in, and then the clock stops. As slave it follows an external serial clock, but only while the external select line is low.

Both directions work at the same time. The master sends on its data-out line and samples its data-in line on the same clock. When a byte completes, the received value is copied into a receive holding register. Software can therefore load the next outgoing byte before it reads the last incoming one. The master never drives the select line; logic outside the block handles it. A completion flag, which can raise an interrupt, and a collision flag tell software about the state of each transfer.

Top module: `spi_port`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low, and `master_oe` and `miso_oe` are both low.
- R2: Register map, selected by `reg_addr`. Address 0 is control: bit0 enable, bit1 master, bit2 LSB-first, bit3 clock idle level, bit4 phase, bits 6:5 rate, bit7 interrupt enable. Address 1 is status: bit7 done, bit6 collision, bit0 double-speed (the only bit that can be written). Address 2 writes the transmit byte and reads the receive holding register.
- R3: In master mode, a data write made while no transfer is running produces exactly 16 toggles of `sck_out`. After that, `sck_out` stays at the clock idle level.
- R4: The `sck_out` half period, in system clocks, is 2, 8, 32 or 64 for rate codes 0 to 3, and half that when double-speed is set. The full divisors are therefore 2, 4, 8, 16, 32, 64 and 128, and divide-by-64 can be reached with two codes.
- R5: `mosi_out` is stable at each sampling edge. The sampling edge is the leading edge (the one leaving the idle level) when phase is 0, and the trailing edge when phase is 1. Bits go out MSB first, or LSB first when bit2 is set.
- R6: The bits sampled from `miso_in` on the sampling edges end up in the receive holding register, in the selected bit order.
- R7: Done is set when a byte completes, in either mode. `irq` is high while done and interrupt enable are both set.
- R8: Done and collision clear only when a status read that saw either flag set is followed by a data-register access. A data access that has no such status read before it leaves both flags set.
- R9: A data write during a transfer is discarded. It sets collision, and the byte in flight and the byte received are unchanged.
- R10: In slave mode with `ss_n` high, `miso_oe` is low and `sck_in` edges shift nothing and complete nothing.
- R11: In slave mode with `ss_n` low, the block samples `mosi_in` and drives `miso_out` on `sck_in` edges, using the same edge and bit-order rules as the master. The eighth sample completes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock when master |
| mosi_out | output | 1 | Serial data out when master |
| master_oe | output | 1 | Drive enable for sck_out and mosi_out |
| miso_in | input | 1 | Serial data in when master |
| sck_in | input | 1 | Serial clock when slave |
| mosi_in | input | 1 | Serial data in when slave |
| ss_n | input | 1 | Slave select, active low |
| miso_out | output | 1 | Serial data out when slave |
| miso_oe | output | 1 | Drive enable for miso_out |

## Verification
The assertions assume that the slave inputs `sck_in`, `mosi_in` and `ss_n` change slowly compared with `clk`, so that each level passes through the two-stage synchronizer. They also assume that the control register is not rewritten while a transfer is running, and that a read and a write never come in the same cycle. The stimulus keeps within these limits. Its slave half periods are eight system clocks long. It writes control only while the block is idle. Its register accesses are single-strobe cycles, driven one nanosecond after the clock edge.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_out,
  output logic       mosi_out,
  output logic       master_oe,
  input  logic       miso_in,
  input  logic       sck_in,
  input  logic       mosi_in,
  input  logic       ss_n,
  output logic       miso_out,
  output logic       miso_oe
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [7:0] ctrl, sh, rbuf;
  logic       dbl, done, wcol, armed, busy, obit, sck_r;
  logic [3:0] ecnt;
  logic [6:0] dcnt, half;
  logic [2:0] sck_sy;
  logic [1:0] mosi_sy, ss_sy;

  wire       en   = ctrl[0];
  wire       mst  = ctrl[1];
  wire       lsbf = ctrl[2];
  wire       cpol = ctrl[3];
  wire       cpha = ctrl[4];
  wire       ie   = ctrl[7];
  wire       slv  = en && !mst;
  wire       ss_act = !ss_sy[1];
  wire       sck_s  = sck_sy[1];
  wire       sck_p  = sck_sy[2];
  wire       mosi_s = mosi_sy[1];

  wire data_wr = reg_wr && reg_addr == A_DATA;
  wire data_rd = reg_rd && reg_addr == A_DATA;
  wire xfer    = mst ? busy : (ss_act && ecnt != 4'd0);
  wire m_tick  = busy && dcnt == half - 7'd1;
  wire m_samp  = (sck_r == cpol) ^ cpha;
  wire s_edge  = slv && ss_act && sck_s != sck_p;
  wire s_samp  = (sck_p == cpol) ^ cpha;

  function automatic logic outb(input logic [7:0] v, input logic lf);
    return lf ? v[0] : v[7];
  endfunction

  function automatic logic [7:0] shin(input logic [7:0] v, input logic b, input logic lf);
    return lf ? {b, v[7:1]} : {v[6:0], b};
  endfunction

  always_comb begin
    case (ctrl[6:5])
      2'd0:    half = 7'd2;
      2'd1:    half = 7'd8;
      2'd2:    half = 7'd32;
      default: half = 7'd64;
    endcase
    if (dbl) half = half >> 1;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_STAT:  reg_rdata = {done, wcol, 5'd0, dbl};
      A_DATA:  reg_rdata = rbuf;
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      mosi_sy <= '0;
      ss_sy   <= '1;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_in};
      mosi_sy <= {mosi_sy[0], mosi_in};
      ss_sy   <= {ss_sy[0], ss_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; dbl <= 1'b0; done <= 1'b0; wcol <= 1'b0; armed <= 1'b0;
      busy <= 1'b0; sh <= '0; rbuf <= '0; obit <= 1'b0; sck_r <= 1'b0;
      ecnt <= '0; dcnt <= '0;
    end else begin
      if (!busy) sck_r <= cpol;
      if (reg_wr && reg_addr == A_CTRL && !xfer) ctrl <= reg_wdata;
      if (reg_wr && reg_addr == A_STAT) dbl <= reg_wdata[0];
      if (reg_rd && reg_addr == A_STAT && (done || wcol)) armed <= 1'b1;
      if ((data_wr || data_rd) && armed) begin
        done <= 1'b0; wcol <= 1'b0; armed <= 1'b0;
      end
      if (data_wr) begin
        if (xfer) wcol <= 1'b1;
        else if (en) begin
          sh   <= reg_wdata;
          obit <= outb(reg_wdata, lsbf);
          if (mst) begin
            busy <= 1'b1; dcnt <= '0; ecnt <= '0;
          end
        end
      end
      if (busy) begin
        if (m_tick) begin
          dcnt  <= '0;
          sck_r <= ~sck_r;
          ecnt  <= ecnt + 4'd1;
          if (m_samp) sh <= shin(sh, miso_in, lsbf);
          else        obit <= outb(sh, lsbf);
          if (ecnt == 4'd15) begin
            busy <= 1'b0;
            done <= 1'b1;
            rbuf <= m_samp ? shin(sh, miso_in, lsbf) : sh;
          end
        end else dcnt <= dcnt + 7'd1;
      end
      if (slv) begin
        if (!ss_act) ecnt <= '0;
        else if (s_edge) begin
          if (s_samp) begin
            sh   <= shin(sh, mosi_s, lsbf);
            ecnt <= (ecnt == 4'd7) ? 4'd0 : ecnt + 4'd1;
            if (ecnt == 4'd7) begin
              done <= 1'b1;
              rbuf <= shin(sh, mosi_s, lsbf);
            end
          end else obit <= outb(sh, lsbf);
        end
      end
    end
  end

  assign irq       = ie && done;
  assign sck_out   = sck_r;
  assign mosi_out  = obit;
  assign master_oe = en && mst;
  assign miso_out  = obit;
  assign miso_oe   = slv && ss_act;
endmodule

module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic       ss_n,
  input logic       sck_out,
  input logic       miso_oe,
  input logic [7:0] ctrl,
  input logic       busy,
  input logic       done,
  input logic       wcol,
  input logic       armed,
  input logic [1:0] ss_sy
);
  p_reset_quiet_r1: assert property (@(posedge clk) $past(!rst_n) |-> !done && !wcol && !busy);

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(ctrl)) |-> sck_out == ctrl[3]);

  p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) || $past(!ss_sy[1]));

  p_clear_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(armed));

  p_wcol_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(reg_wr && reg_addr == 2'd2));

  p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> $past(!ss_n, 2));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .ss_n(ss_n),
  .sck_out(sck_out), .miso_oe(miso_oe), .ctrl(ctrl), .busy(busy), .done(done),
  .wcol(wcol), .armed(armed), .ss_sy(ss_sy)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq, sck_out, mosi_out, master_oe, miso_out, miso_oe;
  logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1;
  wire        miso_in = ~mosi_out;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  spi_port dut (.*);

  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {8'h03, 8'h00, 8'hA5, 8'd2},
    {8'h27, 8'h00, 8'h3C, 8'd8},
    {8'h1B, 8'h01, 8'h81, 8'd1},
    {8'h53, 8'h00, 8'h5A, 8'd32},
    {8'h6F, 8'h01, 8'hC3, 8'd32},
    {8'h63, 8'h00, 8'h0F, 8'd64}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] rev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic master_run(input logic [7:0] c, input logic [7:0] db, input logic [7:0] b,
                            input int half, input string tag);
    logic [7:0] cap = '0, d;
    logic prev;
    int tog = 0, t1 = 0, hm = 0, k = 0;
    wr(2'd0, c);
    wr(2'd1, db);
    prev = sck_out;
    wr(2'd2, b);
    while (k < 3000 && !(tog == 16 && k > t1 + 4 * half)) begin
      if (sck_out != prev) begin
        tog++;
        if (tog == 1) t1 = k;
        if (tog == 2) hm = k - t1;
        if ((sck_out != c[3]) != c[4]) cap = {cap[6:0], mosi_out};
        prev = sck_out;
      end
      k++;
      @(posedge clk); #1;
    end
    chk(tog == 16, {"R3 toggle count ", tag}, tog, 16);
    chk(sck_out == c[3], {"R3 idle level ", tag}, sck_out, c[3]);
    chk(hm == half, {"R4 half period ", tag}, hm, half);
    chk(cap == (c[2] ? rev(b) : b), {"R5 mosi order ", tag}, cap, c[2] ? rev(b) : b);
    rd(2'd1, d);
    chk(d[7] == 1'b1, {"R7 done ", tag}, d, 8'h80);
    rd(2'd2, d);
    chk(d == ~b, {"R6 receive ", tag}, d, ~b);
    rd(2'd1, d);
    chk(d[7:6] == 2'b00, {"R8 cleared ", tag}, d[7:6], 0);
  endtask

  task automatic slave_run(input logic [7:0] c, input logic [7:0] load, input logic [7:0] v,
                           input string tag);
    logic [7:0] cap = '0, d;
    logic b;
    wr(2'd0, c);
    wr(2'd2, load);
    sck_in = c[3];
    repeat (8) @(posedge clk);
    #1 ss_n = 1'b0;
    repeat (8) @(posedge clk);
    #1 chk(miso_oe == 1'b1, {"R11 miso enabled ", tag}, miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      b = c[2] ? v[i] : v[7-i];
      if (!c[4]) begin
        mosi_in = b;
        repeat (8) @(posedge clk);
        #1 cap = {cap[6:0], miso_out};
        sck_in = ~c[3];
        repeat (8) @(posedge clk);
        #1 sck_in = c[3];
      end else begin
        sck_in = ~c[3]; mosi_in = b;
        repeat (8) @(posedge clk);
        #1 cap = {cap[6:0], miso_out};
        sck_in = c[3];
        repeat (8) @(posedge clk);
        #1;
      end
    end
    repeat (6) @(posedge clk);
    #1 ss_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(cap == (c[2] ? rev(load) : load), {"R11 miso bits ", tag}, cap, c[2] ? rev(load) : load);
    rd(2'd1, d);
    chk(d[7] == 1'b1, {"R7 slave done ", tag}, d, 8'h80);
    rd(2'd2, d);
    chk(d == v, {"R11 slave receive ", tag}, d, v);
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    rd(2'd0, d); chk(d == 8'h00, "R1 control", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 status", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 receive", d, 0);
    chk(!irq && !master_oe && !miso_oe, "R1 outputs", {irq, master_oe, miso_oe}, 0);

    for (int i = 0; i < NV; i++)
      master_run(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]), $sformatf("v%0d", i));

    // R7 interrupt
    wr(2'd0, 8'h83); wr(2'd1, 8'h00);
    chk(master_oe == 1'b1, "R2 master enable", master_oe, 1);
    wr(2'd2, 8'h12);
    repeat (60) @(posedge clk); #1;
    chk(irq == 1'b1, "R7 irq raised", irq, 1);
    // R8 data access without status read keeps flags
    rd(2'd2, d);
    rd(2'd1, d); chk(d[7] == 1'b1, "R8 no clear without status read", d, 8'h80);
    rd(2'd2, d); chk(d == 8'hED, "R6 receive irq case", d, 8'hED);
    #1 chk(irq == 1'b0, "R7 irq cleared", irq, 0);

    // R9 collision
    wr(2'd0, 8'h63);
    wr(2'd2, 8'h96);
    repeat (20) @(posedge clk); #1;
    wr(2'd2, 8'h11);
    repeat (1200) @(posedge clk); #1;
    rd(2'd1, d); chk(d == 8'hC0, "R9 collision and done", d, 8'hC0);
    rd(2'd2, d); chk(d == 8'h69, "R9 byte in flight kept", d, 8'h69);
    rd(2'd1, d); chk(d == 8'h00, "R8 both flags cleared", d, 0);

    // R10 slave ignores clock with select high
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hAA);
    for (int i = 0; i < 16; i++) begin
      repeat (8) @(posedge clk);
      #1 sck_in = ~sck_in; mosi_in = ~mosi_in;
      chk(miso_oe == 1'b0, "R10 miso disabled", miso_oe, 0);
    end
    repeat (8) @(posedge clk); #1;
    rd(2'd1, d); chk(d[7] == 1'b0, "R10 no completion", d, 0);
    rd(2'd2, d); chk(d == 8'h69, "R10 receive unchanged", d, 8'h69);

    slave_run(8'h01, 8'hB4, 8'h5C, "mode0 msb");
    slave_run(8'h1D, 8'h2D, 8'hE1, "mode3 lsb");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule